// File: doc/BRIEF.md
# JESD204 Transport-Layer Sample Unpacker

This block sits behind a JESD204 link-layer receiver and turns its wide per-cycle parallel bus into 12-bit converter samples. The link core delivers one 32-bit word per lane per clock, concatenated lane by lane. Each word arrives with its byte order reversed: the first byte received on the wire sits in the least significant byte. The unpacker cuts the bus into lanes and puts each lane's bytes back into wire order. It then pairs two consecutive valid words per lane into a 64-bit lane frame.

Each lane frame carries five 12-bit samples and a 4-bit tail, which is dropped. With sixteen lanes, one frame period yields 80 samples. The block presents them as two 40-sample words on successive output cycles, with the lowest-numbered sample in the most significant field. A frame-start qualifier on the input sets the two-cycle phase. An input-valid qualifier lets the upstream core pause between words without losing a half-collected frame.

Top module: `jesd_xport_unpack`

## Requirements
- R1: Input bits [32L+31:32L] form the word of lane L, for lanes 0 to 15.
- R2: Within a lane word, the byte in bits 7:0 is the first received byte and becomes bits 31:24 of the restored word. Bits 15:8 become 23:16, bits 23:16 become 15:8, and bits 31:24 become 7:0.
- R3: A restored word accepted with `fs_in` and `vld_in` both high forms bits 63:32 of the lane frame. The next accepted word forms bits 31:0.
- R4: In a lane frame with base index b, bits 63:52, 51:40, 39:28, 27:16 and 15:4 hold samples b, b+16, b+32, b+48 and b+64. Bits 3:0 are tail and have no effect on any output.
- R5: Lanes 0 to 7 have base index 2L. Lanes 8 to 15 have base index 2(L-8)+1.
- R6: On the first output cycle of a frame, `half_hi` is 0 and sample j (0 to 39) sits in `smp_out[479-12j -: 12]`. On the next cycle, `half_hi` is 1 and sample 40+j sits in the same field. A run of valid output never starts with `half_hi` high.
- R7: The lower half becomes valid two clocks after the cycle that presents the second frame word. With no pause between the two words, this is three clocks after the first word. The upper half follows one clock later.
- R8: Frames sent back to back, four consecutive valid words, give four consecutive valid output cycles with no gap.
- R9: While `vld_in` is low, `dat_in` and `fs_in` are ignored and a held first word is kept. Output for a frame interrupted this way matches the uninterrupted case.
- R10: A valid word without `fs_in` and with no first word held is dropped and produces no output. A second `fs_in` word while a first word is held replaces the held word.
- R11: Reset drives `smp_vld`, `half_hi` and `smp_out` to 0 and discards any held first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_in | input | 1 | Input word qualifier |
| fs_in | input | 1 | First word of a 64-bit lane frame (used only with vld_in) |
| dat_in | input | 512 | Sixteen byte-reversed 32-bit lane words, lane 0 in bits 31:0 |
| smp_vld | output | 1 | Output samples are valid |
| half_hi | output | 1 | 0: samples 0-39 present, 1: samples 40-79 present |
| smp_out | output | 480 | Forty 12-bit samples, lowest-numbered in the top field |

## Verification
A ramp of distinct sample values shows that every one of the 80 samples lands in exactly one field. This exposes swapped bytes, wrong lane bases and straddled fields that are split at the wrong bit. An alternating 0xAAA/0x555 pattern tells even-base lanes from odd-base lanes. A scrambled pattern sent with the tail nibble set to ones shows whether tail bits leak into a neighbouring sample. Paused, orphaned, restarted, back-to-back and reset-interrupted frames separate correct phase tracking from plain timing luck.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

   // Phase of the per-frame collector: empty, or holding the first word.
   typedef enum logic {
      ACC_EMPTY = 1'b0,
      ACC_HOLD  = 1'b1
   } acc_state_e;

   // First sample index carried by a lane. The lower half of the lanes take
   // even indices and the upper half take odd ones.
   function automatic int lane_base(input int lane, input int lanes);
      return (lane < lanes / 2) ? 2 * lane : 2 * (lane - lanes / 2) + 1;
   endfunction

endpackage

// File: rtl/jtu_lane_swap.sv
module jtu_lane_swap #(
   parameter int LANES     = 16,
   parameter int LANE_BITS = 32
) (
   input  logic [LANES*LANE_BITS-1:0] raw_bus,
   output logic [LANES*LANE_BITS-1:0] ord_bus
);

   localparam int NBYTES = LANE_BITS / 8;

   if (LANE_BITS % 8 != 0) begin : g_bad_lane
      $error("jtu_lane_swap: LANE_BITS must be a whole number of bytes");
   end

   // R1 R2: slice into lanes, mirror byte order inside each lane
   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
         assign ord_bus[gl*LANE_BITS + (NBYTES-1-gb)*8 +: 8] =
                raw_bus[gl*LANE_BITS + gb*8 +: 8];
      end
   end

endmodule

// File: rtl/jtu_frame_acc.sv
module jtu_frame_acc
   import jtu_pkg::*;
#(
   parameter int LANES       = 16,
   parameter int LANE_BITS   = 32,
   parameter int SAMPLE_BITS = 12,
   parameter int SLOTS       = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               vld_in,
   input  logic                               fs_in,
   input  logic [LANES*LANE_BITS-1:0]         lane_bus,
   output logic                               frame_done,
   output logic [LANES*SLOTS*SAMPLE_BITS-1:0] pay_bus
);

   localparam int BUS_W      = LANES * LANE_BITS;
   localparam int FRAME_BITS = 2 * LANE_BITS;
   localparam int PAY_BITS   = SLOTS * SAMPLE_BITS;
   localparam int TAIL_BITS  = FRAME_BITS - PAY_BITS;

   if (TAIL_BITS < 0 || TAIL_BITS >= LANE_BITS) begin : g_bad_tail
      $error("jtu_frame_acc: payload must fill more than one lane word of the frame");
   end

   logic             s1_valid;
   logic             s1_fs;
   logic [BUS_W-1:0] s1_bus;
   logic [BUS_W-1:0] acc_bus;
   acc_state_e       acc_st;

   // Input register stage; data only moves on a valid word (R9)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_fs    <= 1'b0;
      end else begin
         s1_valid <= vld_in;
         s1_fs    <= vld_in & fs_in;
      end
   end

   always_ff @(posedge clk) begin
      if (vld_in) s1_bus <= lane_bus;
   end

   // Frame phase: a flagged word opens (or restarts) a frame; the next
   // valid word closes it; an unflagged word with nothing held is dropped
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_st <= ACC_EMPTY;
      end else if (s1_valid) begin
         acc_st <= s1_fs ? ACC_HOLD : ACC_EMPTY;
      end
   end

   always_ff @(posedge clk) begin
      if (s1_valid && s1_fs) acc_bus <= s1_bus;
   end

   assign frame_done = s1_valid && !s1_fs && (acc_st == ACC_HOLD);

   // R3: held word is the frame's high half; tail is cut off the low half
   for (genvar gl = 0; gl < LANES; gl++) begin : g_frame
      assign pay_bus[gl*PAY_BITS +: PAY_BITS] =
         {acc_bus[gl*LANE_BITS +: LANE_BITS],
          s1_bus[gl*LANE_BITS + TAIL_BITS +: LANE_BITS - TAIL_BITS]};
   end

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_st == ACC_HOLD && !s1_valid) |=> (acc_st == ACC_HOLD && $stable(acc_bus)));

   // R10
   hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_st == ACC_HOLD) |-> $past(vld_in && fs_in, 2));

endmodule

// File: rtl/jtu_sample_map.sv
module jtu_sample_map
   import jtu_pkg::*;
#(
   parameter int LANES       = 16,
   parameter int SAMPLE_BITS = 12,
   parameter int SLOTS       = 5
) (
   input  logic [LANES*SLOTS*SAMPLE_BITS-1:0]   pay_bus,
   output logic [LANES*SLOTS*SAMPLE_BITS/2-1:0] lo_half,
   output logic [LANES*SLOTS*SAMPLE_BITS/2-1:0] hi_half
);

   localparam int PAY_BITS = SLOTS * SAMPLE_BITS;
   localparam int TOTAL    = LANES * SLOTS;
   localparam int HALF     = TOTAL / 2;

   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("jtu_sample_map: LANES must be even");
   end

   // R4 R5 R6: slot m of lane l carries sample base(l) + LANES*m; place it
   // in the half and field that its index selects, lowest index on top
   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      for (genvar gm = 0; gm < SLOTS; gm++) begin : g_slot
         localparam int IDX = lane_base(gl, LANES) + LANES * gm;
         localparam int DST = (HALF - 1 - (IDX % HALF)) * SAMPLE_BITS;
         localparam int SRC = gl * PAY_BITS + PAY_BITS - (gm + 1) * SAMPLE_BITS;
         if (IDX < HALF) begin : g_lo
            assign lo_half[DST +: SAMPLE_BITS] = pay_bus[SRC +: SAMPLE_BITS];
         end else begin : g_hi
            assign hi_half[DST +: SAMPLE_BITS] = pay_bus[SRC +: SAMPLE_BITS];
         end
      end
   end

endmodule

// File: rtl/jtu_half_out.sv
module jtu_half_out #(
   parameter int HALF_BITS = 480
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_done,
   input  logic [HALF_BITS-1:0] lo_half,
   input  logic [HALF_BITS-1:0] hi_half,
   output logic                 smp_vld,
   output logic                 half_hi,
   output logic [HALF_BITS-1:0] smp_out
);

   logic                 pend_hi;
   logic [HALF_BITS-1:0] hi_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_vld <= 1'b0;
         half_hi <= 1'b0;
         smp_out <= '0;
         pend_hi <= 1'b0;
      end else if (frame_done) begin
         smp_vld <= 1'b1;
         half_hi <= 1'b0;
         smp_out <= lo_half;
         pend_hi <= 1'b1;
      end else if (pend_hi) begin
         smp_vld <= 1'b1;
         half_hi <= 1'b1;
         smp_out <= hi_hold;
         pend_hi <= 1'b0;
      end else begin
         smp_vld <= 1'b0;
         half_hi <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (frame_done) hi_hold <= hi_half;
   end

   // R7
   lower_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (smp_vld && !half_hi));

   // R6
   upper_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !half_hi) |=> (smp_vld && half_hi));

   // R6
   upper_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && half_hi) |=> !(smp_vld && half_hi));

   // R6
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(smp_vld) |-> !half_hi);

   // R8
   no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !pend_hi);

endmodule

// File: rtl/jesd_xport_unpack.sv
module jesd_xport_unpack #(
   parameter int LANES       = 16,
   parameter int LANE_BITS   = 32,
   parameter int SAMPLE_BITS = 12,
   parameter int SLOTS       = 5
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 vld_in,
   input  logic                                 fs_in,
   input  logic [LANES*LANE_BITS-1:0]           dat_in,
   output logic                                 smp_vld,
   output logic                                 half_hi,
   output logic [LANES*SLOTS*SAMPLE_BITS/2-1:0] smp_out
);

   localparam int BUS_W     = LANES * LANE_BITS;
   localparam int PAY_W     = LANES * SLOTS * SAMPLE_BITS;
   localparam int HALF_BITS = PAY_W / 2;

   if (LANES < 2 || LANES % 2 != 0) begin : g_bad_lanes
      $error("jesd_xport_unpack: LANES must be even and at least 2");
   end
   if (SAMPLE_BITS < 1 || SLOTS < 1) begin : g_bad_slot
      $error("jesd_xport_unpack: SAMPLE_BITS and SLOTS must be positive");
   end
   if (SLOTS * SAMPLE_BITS > 2 * LANE_BITS) begin : g_bad_fit
      $error("jesd_xport_unpack: samples do not fit in a two-word lane frame");
   end

   logic [BUS_W-1:0]     ord_bus;
   logic [PAY_W-1:0]     pay_bus;
   logic                 frame_done;
   logic [HALF_BITS-1:0] lo_half;
   logic [HALF_BITS-1:0] hi_half;

   jtu_lane_swap #(
      .LANES     (LANES),
      .LANE_BITS (LANE_BITS)
   ) u_swap (
      .raw_bus (dat_in),
      .ord_bus (ord_bus)
   );

   jtu_frame_acc #(
      .LANES       (LANES),
      .LANE_BITS   (LANE_BITS),
      .SAMPLE_BITS (SAMPLE_BITS),
      .SLOTS       (SLOTS)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_in     (vld_in),
      .fs_in      (fs_in),
      .lane_bus   (ord_bus),
      .frame_done (frame_done),
      .pay_bus    (pay_bus)
   );

   jtu_sample_map #(
      .LANES       (LANES),
      .SAMPLE_BITS (SAMPLE_BITS),
      .SLOTS       (SLOTS)
   ) u_map (
      .pay_bus (pay_bus),
      .lo_half (lo_half),
      .hi_half (hi_half)
   );

   jtu_half_out #(
      .HALF_BITS (HALF_BITS)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .lo_half    (lo_half),
      .hi_half    (hi_half),
      .smp_vld    (smp_vld),
      .half_hi    (half_hi),
      .smp_out    (smp_out)
   );

endmodule

// File: tb/jesd_xport_unpack_bench.sv
`timescale 1ns/1ps
module jesd_xport_unpack_bench;

   localparam int NL   = 16;
   localparam int BW   = NL * 32;
   localparam int NS   = 80;
   localparam int HALF = 40;
   localparam int HB   = HALF * 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          vld_in;
   logic          fs_in;
   logic [BW-1:0] dat_in;
   logic          smp_vld;
   logic          half_hi;
   logic [HB-1:0] smp_out;

   int checks = 0;
   int bad    = 0;

   logic [11:0] smp  [2][NS];
   logic [3:0]  tail [2];

   always #2 clk = ~clk;

   jesd_xport_unpack u_jesd_xport_unpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (vld_in),
      .fs_in   (fs_in),
      .dat_in  (dat_in),
      .smp_vld (smp_vld),
      .half_hi (half_hi),
      .smp_out (smp_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // kind 0 ramp, 1 alternating, 2 scrambled, 3 descending
   task automatic fill(input int fi, input int kind, input logic [3:0] t);
      for (int n = 0; n < NS; n++) begin
         case (kind)
            0:       smp[fi][n] = 12'(n + 1);
            1:       smp[fi][n] = (n % 2 == 1) ? 12'h555 : 12'hAAA;
            2:       smp[fi][n] = 12'((n * 157 + 49) & 12'hFFF);
            default: smp[fi][n] = 12'(12'hFFF - n);
         endcase
      end
      tail[fi] = t;
   endtask

   // R1 R2 R3 R4 R5: build the bus the link core would present
   task automatic drive_word(input int fi, input bit second, input bit fs);
      logic [BW-1:0] bus;
      for (int l = 0; l < NL; l++) begin
         int          b;
         logic [63:0] f;
         logic [31:0] w;
         b = (l < NL / 2) ? 2 * l : 2 * (l - NL / 2) + 1;
         f = {smp[fi][b], smp[fi][b+16], smp[fi][b+32], smp[fi][b+48],
              smp[fi][b+64], tail[fi]};
         w = second ? f[31:0] : f[63:32];
         bus[l*32 +: 32] = {w[7:0], w[15:8], w[23:16], w[31:24]};
      end
      vld_in = 1'b1;
      fs_in  = fs;
      dat_in = bus;
   endtask

   task automatic drive_idle(input bit fs);
      vld_in = 1'b0;
      fs_in  = fs;
      dat_in = {NL{32'hDEADBEEF}};
   endtask

   task automatic check_half(input int fi, input bit hi, input string req);
      logic [HB-1:0] exp;
      for (int j = 0; j < HALF; j++)
         exp[(HALF-1-j)*12 +: 12] = smp[fi][(hi ? HALF : 0) + j];
      checks++;
      if (smp_vld !== 1'b1 || half_hi !== hi || smp_out !== exp) begin
         bad++;
         $display("FAIL %s: vld=%0b hi=%0b data=%h expected vld=1 hi=%0b data=%h",
                  req, smp_vld, half_hi, smp_out, hi, exp);
      end
   endtask

   task automatic check_idle(input string req);
      checks++;
      if (smp_vld !== 1'b0) begin
         bad++;
         $display("FAIL %s: vld=%0b expected vld=0", req, smp_vld);
      end
   endtask

   // R11 reset state
   task automatic t_reset();
      checks++;
      if (smp_vld !== 1'b0 || half_hi !== 1'b0 || smp_out !== '0) begin
         bad++;
         $display("FAIL R11: vld=%0b hi=%0b data=%h expected 0 0 0",
                  smp_vld, half_hi, smp_out);
      end
   endtask

   // R4 R6 R7: one frame with no pause
   task automatic t_single(input int kind, input logic [3:0] t, input string req);
      fill(0, kind, t);
      drive_word(0, 1'b0, 1'b1); step();
      drive_word(0, 1'b1, 1'b0); step();
      drive_idle(1'b0);          step();
      check_half(0, 1'b0, {req, " R7 lower at 3 clocks"});
      step();
      check_half(0, 1'b1, {req, " R6 upper"});
      step();
      check_idle({req, " R6 end of frame"});
   endtask

   // R9: pause with frame-start and junk data between the two words
   task automatic t_stall();
      fill(0, 2, 4'h5);
      drive_word(0, 1'b0, 1'b1); step();
      drive_idle(1'b1); step();
      check_idle("R9 no output during pause");
      drive_idle(1'b0); step();
      drive_idle(1'b1); step();
      check_idle("R9 no output during pause");
      drive_word(0, 1'b1, 1'b0); step();
      drive_idle(1'b0);          step();
      check_half(0, 1'b0, "R9 lower after pause");
      step();
      check_half(0, 1'b1, "R9 upper after pause");
   endtask

   // R10: orphan words dropped, then a restart replaces a held word
   task automatic t_align();
      fill(0, 3, 4'h0);
      fill(1, 2, 4'hA);
      drive_word(0, 1'b1, 1'b0); step();
      drive_word(0, 1'b0, 1'b0); step();
      drive_idle(1'b0);
      for (int k = 0; k < 4; k++) begin
         step();
         check_idle("R10 orphan words dropped");
      end
      drive_word(1, 1'b0, 1'b1); step();
      drive_word(0, 1'b0, 1'b1); step();
      drive_word(0, 1'b1, 1'b0); step();
      drive_idle(1'b0);          step();
      check_half(0, 1'b0, "R10 restart lower");
      step();
      check_half(0, 1'b1, "R10 restart upper");
   endtask

   // R8: two frames back to back
   task automatic t_b2b();
      fill(0, 0, 4'h3);
      fill(1, 3, 4'hC);
      drive_word(0, 1'b0, 1'b1); step();
      drive_word(0, 1'b1, 1'b0); step();
      drive_word(1, 1'b0, 1'b1); step();
      check_half(0, 1'b0, "R8 frame A lower");
      drive_word(1, 1'b1, 1'b0); step();
      check_half(0, 1'b1, "R8 frame A upper");
      drive_idle(1'b0); step();
      check_half(1, 1'b0, "R8 frame B lower");
      step();
      check_half(1, 1'b1, "R8 frame B upper");
      step();
      check_idle("R8 stream end");
   endtask

   // R11: reset between the two words discards the held word
   task automatic t_mid_reset();
      fill(0, 0, 4'h0);
      drive_word(0, 1'b0, 1'b1); step();
      rst_n = 1'b0;
      drive_idle(1'b0); step();
      step();
      t_reset();
      rst_n = 1'b1;
      drive_word(0, 1'b1, 1'b0); step();
      drive_idle(1'b0);
      for (int k = 0; k < 3; k++) begin
         step();
         check_idle("R11 held word discarded by reset");
      end
   endtask

   initial begin
      rst_n = 1'b0;
      drive_idle(1'b0);
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_single(0, 4'h0, "R4 R5 ramp");
      t_single(1, 4'h0, "R5 alternating");
      t_single(2, 4'hF, "R4 tail ones scrambled");
      t_stall();
      t_align();
      t_b2b();
      t_mid_reset();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule